// File: doc/BRIEF.md
# Rectangle Sprite Framebuffer Painter

This block keeps a 16x16 framebuffer of 15-bit colour pixels and repaints it from a table of 32 rectangle sprites each time an update request arrives. Software fills the table through a word-addressed write port. Each sprite has two words. The corner word holds the two x bounds and the two y bounds. The colour word holds the colour and an enable bit.

On a request, the painter takes a snapshot of the table. It then visits the entries from the lowest index to the highest. For each enabled entry whose bounds are in order, it writes every pixel of the inclusive rectangle into the framebuffer, one pixel per cycle. The framebuffer is never cleared. A later sprite therefore covers an earlier one, and pixels that no sprite touches keep their old value. A frame can be built up over several updates. A registered read port lets a display fetch any pixel by its coordinates.

Top module: `sprite_painter`

## Requirements
- R1: Table word address `tbl_addr` selects sprite `tbl_addr[5:1]`. With `tbl_addr[0]`=0 the write goes to that sprite's corner word, and with 1 it goes to its colour word.
- R2: Corner word fields: x1 = bits [15:12], x2 = bits [11:8], y1 = bits [7:4], y2 = bits [3:0].
- R3: An enabled sprite paints every pixel with x1<=x<=x2 and y1<=y<=y2, both bounds inclusive, and no other pixel.
- R4: Colour word bits [14:0] are the pixel colour and bit 15 is the enable. A sprite whose bit 15 is 0 changes no pixel.
- R5: Sprites are painted in ascending index order, so where rectangles overlap the higher index wins.
- R6: Pixels that no enabled sprite covers keep the value they held before the update.
- R7: A request while idle raises `busy` on the next cycle. One request paints all 32 entries, then `busy` falls. The framebuffer is written only while `busy` is high.
- R8: An entry with x1>x2 or y1>y2 paints nothing.
- R9: A table write made while `busy` is high does not affect the walk in progress. It takes effect from the next update.
- R10: A request made while `busy` is high is remembered. A second full walk follows at once, with `busy` held high throughout.
- R11: `pix_data` returns the framebuffer pixel at (`pix_x`, `pix_y`) one cycle after the address is presented.
- R12: After reset, `busy` is low, no request is pending, and every table word is zero. All sprites are therefore disabled, and a walk over this table takes 32 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_we | input | 1 | Table write strobe |
| tbl_addr | input | 6 | Table word address (sprite index, word select) |
| tbl_wdata | input | 16 | Table write data |
| upd_req | input | 1 | Update request pulse |
| pix_x | input | 4 | Read port column |
| pix_y | input | 4 | Read port row |
| busy | output | 1 | High while a walk is in progress |
| pix_data | output | 15 | Pixel colour read back |

## Verification
The assertions check several rules on every cycle. Every framebuffer write lies inside the inclusive rectangle of the entry being walked, and that entry is enabled. Nothing is written while idle. A request, whether made while idle or while busy, always leaves `busy` high on the next cycle. Overlap order, untouched pixels keeping their value, write isolation during a walk, and exact walk lengths depend on whole-frame contents and cycle counts, so only the bench scenarios can show them. The bench compares every pixel against a reference model and measures `busy` durations.

// File: rtl/sprite_painter.sv
module sprite_painter #(
  parameter int NUM_SPR = 32,
  parameter int COORD_W = 4,
  parameter int COLOR_W = 15
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              tbl_we,
  input  logic [$clog2(NUM_SPR):0]          tbl_addr,
  input  logic [4*COORD_W-1:0]              tbl_wdata,
  input  logic                              upd_req,
  input  logic [COORD_W-1:0]                pix_x,
  input  logic [COORD_W-1:0]                pix_y,
  output logic                              busy,
  output logic [COLOR_W-1:0]                pix_data
);
  localparam int IDX_W  = $clog2(NUM_SPR);
  localparam int ADDR_W = IDX_W + 1;
  localparam int WORD_W = 4 * COORD_W;
  localparam int PIX_AW = 2 * COORD_W;
  localparam int PIX_N  = 1 << PIX_AW;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_SPR - 1);

  typedef enum logic [1:0] {S_IDLE, S_SCAN, S_PAINT} st_t;

  logic [WORD_W-1:0]  sh_corner [NUM_SPR];
  logic [COLOR_W:0]   sh_color  [NUM_SPR];
  logic [WORD_W-1:0]  wk_corner [NUM_SPR];
  logic [COLOR_W:0]   wk_color  [NUM_SPR];
  logic [COLOR_W-1:0] fb        [PIX_N];

  st_t                st;
  logic [IDX_W-1:0]   idx;
  logic [COORD_W-1:0] cx, cy;
  logic               pend;

  logic [WORD_W-1:0]  cur_corner;
  logic [COLOR_W:0]   cur_color;
  logic [COORD_W-1:0] x1, x2, y1, y2;
  logic               draw_ok, last, entry_done, start;
  logic               fb_we;
  logic [PIX_AW-1:0]  fb_waddr;
  logic [COLOR_W-1:0] fb_wdata;

  assign cur_corner = wk_corner[idx];
  assign cur_color  = wk_color[idx];
  assign x1 = cur_corner[4*COORD_W-1 -: COORD_W];
  assign x2 = cur_corner[3*COORD_W-1 -: COORD_W];
  assign y1 = cur_corner[2*COORD_W-1 -: COORD_W];
  assign y2 = cur_corner[COORD_W-1:0];

  assign draw_ok    = cur_color[COLOR_W] && (x1 <= x2) && (y1 <= y2);
  assign last       = (idx == LAST_IDX);
  assign entry_done = ((st == S_SCAN) && !draw_ok) ||
                      ((st == S_PAINT) && (cx == x2) && (cy == y2));
  assign start      = ((st == S_IDLE) && upd_req) ||
                      (entry_done && last && (pend || upd_req));

  assign busy     = (st != S_IDLE);
  assign fb_we    = (st == S_PAINT);
  assign fb_waddr = {cy, cx};
  assign fb_wdata = cur_color[COLOR_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_SPR; i++) begin
        sh_corner[i] <= '0;
        sh_color[i]  <= '0;
      end
    end else if (tbl_we) begin
      if (tbl_addr[0]) sh_color[tbl_addr[ADDR_W-1:1]]  <= tbl_wdata[COLOR_W:0];
      else             sh_corner[tbl_addr[ADDR_W-1:1]] <= tbl_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_SPR; i++) begin
        wk_corner[i] <= '0;
        wk_color[i]  <= '0;
      end
    end else if (start) begin
      wk_corner <= sh_corner;
      wk_color  <= sh_color;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      idx  <= '0;
      cx   <= '0;
      cy   <= '0;
      pend <= 1'b0;
    end else if (start) begin
      st   <= S_SCAN;
      idx  <= '0;
      pend <= 1'b0;
    end else begin
      if (busy && upd_req) pend <= 1'b1;
      case (st)
        S_SCAN: begin
          if (draw_ok) begin
            st <= S_PAINT;
            cx <= x1;
            cy <= y1;
          end else if (last) begin
            st <= S_IDLE;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        S_PAINT: begin
          if (cx != x2) begin
            cx <= cx + 1'b1;
          end else if (cy != y2) begin
            cx <= x1;
            cy <= cy + 1'b1;
          end else if (last) begin
            st <= S_IDLE;
          end else begin
            st  <= S_SCAN;
            idx <= idx + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (fb_we) fb[fb_waddr] <= fb_wdata;
    pix_data <= fb[{pix_y, pix_x}];
  end
endmodule

// File: rtl/sprite_painter_chk.sv
module sprite_painter_chk #(
  parameter int COORD_W = 4,
  parameter int COLOR_W = 15
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 upd_req,
  input logic                 busy,
  input logic                 fb_we,
  input logic [2*COORD_W-1:0] fb_waddr,
  input logic [4*COORD_W-1:0] cur_corner,
  input logic [COLOR_W:0]     cur_color
);
  logic [COORD_W-1:0] wx, wy, bx1, bx2, by1, by2;
  assign wx  = fb_waddr[COORD_W-1:0];
  assign wy  = fb_waddr[2*COORD_W-1 -: COORD_W];
  assign bx1 = cur_corner[4*COORD_W-1 -: COORD_W];
  assign bx2 = cur_corner[3*COORD_W-1 -: COORD_W];
  assign by1 = cur_corner[2*COORD_W-1 -: COORD_W];
  assign by2 = cur_corner[COORD_W-1:0];

  assert_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && upd_req) |=> busy);

  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !fb_we);

  assert_pending_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && upd_req) |=> busy);

  assert_enabled_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fb_we |-> cur_color[COLOR_W]);

  assert_inside_rect_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fb_we |-> (wx >= bx1 && wx <= bx2 && wy >= by1 && wy <= by2));
endmodule

bind sprite_painter sprite_painter_chk #(.COORD_W(COORD_W), .COLOR_W(COLOR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .upd_req   (upd_req),
  .busy      (busy),
  .fb_we     (fb_we),
  .fb_waddr  (fb_waddr),
  .cur_corner(cur_corner),
  .cur_color (cur_color)
);

// File: tb/sim_sprite_painter.sv
module sim_sprite_painter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tbl_we = 1'b0;
  logic [5:0]  tbl_addr = '0;
  logic [15:0] tbl_wdata = '0;
  logic        upd_req = 1'b0;
  logic [3:0]  pix_x = '0, pix_y = '0;
  logic        busy;
  logic [14:0] pix_data;

  int nchk = 0, nfail = 0, cycles = 0;
  bit done = 1'b0;

  logic [15:0] m_corner [32];
  logic [15:0] m_color  [32];
  logic [14:0] m_fb     [256];

  // slot[36:32] x1 x2 y1 y2 [31:16] en[15] colour[14:0]
  localparam logic [36:0] VEC [9] = '{
    {5'd0,  4'd0,  4'd15, 4'd0,  4'd15, 1'b1, 15'h0421},
    {5'd5,  4'd2,  4'd5,  4'd3,  4'd4,  1'b1, 15'h7C00},
    {5'd3,  4'd4,  4'd8,  4'd0,  4'd6,  1'b1, 15'h03E0},
    {5'd7,  4'd0,  4'd15, 4'd0,  4'd15, 1'b0, 15'h1234},
    {5'd9,  4'd9,  4'd4,  4'd0,  4'd15, 1'b1, 15'h6666},
    {5'd10, 4'd15, 4'd15, 4'd15, 4'd15, 1'b1, 15'h7FFF},
    {5'd0,  4'd0,  4'd15, 4'd0,  4'd15, 1'b0, 15'h0000},
    {5'd11, 4'd0,  4'd0,  4'd0,  4'd15, 1'b1, 15'h001F},
    {5'd31, 4'd3,  4'd12, 4'd3,  4'd12, 1'b1, 15'h5555}
  };

  sprite_painter u0 (
    .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
    .tbl_wdata(tbl_wdata), .upd_req(upd_req), .pix_x(pix_x), .pix_y(pix_y),
    .busy(busy), .pix_data(pix_data)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      nchk++;
      nfail++;
      $display("FAIL watchdog R7 actual=%0d expected=<150000 cycles", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  function automatic string vec_tag(int i);
    case (i)
      0: return "R1 R2 R3 background";
      1: return "R3 R11 rectangle";
      2: return "R5 overlap order";
      3: return "R4 disabled";
      4: return "R8 inverted";
      5: return "R3 single pixel";
      6: return "R6 no clear";
      7: return "R3 column";
      default: return "R5 top sprite";
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic void model_paint();
    for (int i = 0; i < 32; i++) begin
      logic [3:0] a, b, c, d;
      {a, b, c, d} = m_corner[i];
      if (m_color[i][15] && a <= b && c <= d)
        for (int y = int'(c); y <= int'(d); y++)
          for (int x = int'(a); x <= int'(b); x++)
            m_fb[y*16 + x] = m_color[i][14:0];
    end
  endfunction

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    tbl_we = 1'b1; tbl_addr = a; tbl_wdata = d;
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic run_update(output int cyc, output bit b0);
    @(negedge clk); upd_req = 1'b1;
    @(negedge clk); upd_req = 1'b0;
    b0 = busy;
    cyc = 0;
    while (busy) begin cyc++; @(negedge clk); end
  endtask

  task automatic compare_fb(input string tag);
    int bad = 0, fa = 0;
    logic [14:0] fv = '0, fe = '0;
    for (int p = 0; p < 256; p++) begin
      @(negedge clk); pix_x = p[3:0]; pix_y = p[7:4];
      @(negedge clk);
      if (pix_data !== m_fb[p]) begin
        if (bad == 0) begin fa = p; fv = pix_data; fe = m_fb[p]; end
        bad++;
      end
    end
    check(bad == 0, $sformatf("%s R11 pixel %0d", tag, fa), fv, fe);
  endtask

  initial begin
    int cyc, L, cnt;
    bit b0;
    for (int i = 0; i < 32; i++) begin m_corner[i] = '0; m_color[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 1'b0, "R12 busy after reset", busy, 0);

    run_update(cyc, b0);
    check(b0 == 1'b1, "R7 busy after request", b0, 1);
    check(cyc == 32, "R12 empty table walk length", cyc, 32);

    foreach (VEC[v]) begin
      logic [36:0] e;
      int s;
      e = VEC[v];
      s = int'(e[36:32]);
      wr({e[36:32], 1'b0}, e[31:16]);
      wr({e[36:32], 1'b1}, e[15:0]);
      m_corner[s] = e[31:16];
      m_color[s]  = e[15:0];
      run_update(cyc, b0);
      model_paint();
      check(b0 && cyc > 0, {vec_tag(v), " R7 walk"}, cyc, 1);
      compare_fb(vec_tag(v));
    end

    // R9: write during walk must not affect it
    @(negedge clk); upd_req = 1'b1;
    @(negedge clk); upd_req = 1'b0;
    wr(6'd63, 16'hA222);
    check(busy == 1'b1, "R9 write landed while busy", busy, 1);
    while (busy) @(negedge clk);
    model_paint();
    compare_fb("R9 current walk unchanged");
    @(negedge clk); pix_x = 4'd7; pix_y = 4'd7;
    @(negedge clk);
    check(pix_data == 15'h5555, "R9 centre keeps old colour", pix_data, 15'h5555);
    m_color[31] = 16'hA222;
    run_update(L, b0);
    model_paint();
    compare_fb("R9 next walk applies write");

    // R10: request during busy gives back-to-back walks
    @(negedge clk); upd_req = 1'b1;
    @(negedge clk); upd_req = 1'b0;
    cnt = 0;
    while (busy) begin
      cnt++;
      upd_req = (cnt == 4);
      @(negedge clk);
    end
    upd_req = 1'b0;
    check(cnt == 2 * L, "R10 back-to-back busy length", cnt, 2 * L);
    model_paint();
    compare_fb("R10 frame after double walk");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule